// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN bit-level receiver and decides where each received frame is kept. A decoded frame (identifier, extended-format flag, remote-request flag, length code and eight payload bytes) arrives with a one-cycle valid strobe. It is compared against a bank of mailboxes. Each mailbox holds an upper and a lower identifier word, an upper and a lower acceptance mask, an enable bit and a direction bit.

The lowest-numbered enabled receive mailbox that accepts the frame takes a copy of the identifier, the length code and the payload. Its pending and interrupt flags are set. If the mailbox was still pending, its message-lost flag is also set. Software configures the bank and clears the flags through a simple word-wide register port with a combinational read path.

Top module: `can_mbox_filter`

## Requirements
- R1: After reset all pending, interrupt and lost flags are 0, every mailbox is disabled, and every register reads 0.
- R2: A standard frame's 11-bit identifier is compared against mailbox upper-word bits 12..2. The upper word carries the mask-enable flag in bit 15, the remote flag in bit 14 and the extended flag in bit 13. With mask-enable 0, the identifier and the remote flag must both be equal.
- R3: An extended frame's 29-bit identifier is compared with identifier bits 28..16 against upper-word bits 12..0 and bits 15..0 against the lower word.
- R4: With mask-enable 1, a mask bit of 1 (13-bit upper mask and 16-bit lower mask, aligned with the identifier words) makes that identifier bit don't-care, and the remote flag is not compared. The extended flag must always be equal, whatever the mask.
- R5: A mailbox accepts a frame only when its enable bit is 1 and its direction bit is 1 (receive).
- R6: When several mailboxes accept a frame, only the lowest-numbered one stores it.
- R7: The edge that samples frm_valid stores the frame in the winning mailbox, so the flags and registers show it from the next cycle. Storing sets the mailbox's pending and interrupt flags. It writes the received identifier and remote/extended flags into the identifier words and keeps mask-enable. It writes the length code into bits 3..0 of the length register. Data word w holds byte 2w in bits 15..8 and byte 2w+1 in bits 7..0, where byte k is frm_data[8k+7:8k]. A store takes precedence over a configuration write to the same mailbox in the same cycle.
- R8: A frame stored in a mailbox whose pending flag is already 1 replaces the mailbox contents and sets that mailbox's lost flag. A frame stored in a mailbox that is not pending leaves the lost flag unchanged.
- R9: Pending, interrupt and lost flags are cleared by writing 1 to the flag's bit. Writing 0 leaves a flag unchanged. A store in the same cycle as a clear leaves the flag set.
- R10: cfg_addr bit 9 selects the mailbox space (1) or the global space (0), and bits 8..4 hold the mailbox number or the global kind. In mailbox space, bits 3..0 select the register: 0 upper id, 1 lower id, 2 upper mask, 3 lower mask, 4 length, 5..8 data words 0..3. In global space the kinds are 0 enable, 1 direction, 2 pending, 3 interrupt and 4 lost, and bits 3..0 select the half (0 for mailboxes 0-15, 1 for mailboxes 16-31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (10) | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| frm_valid | input | 1 | Decoded frame strobe |
| frm_ext | input | 1 | Frame uses the 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Frame identifier (standard uses bits 10..0) |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Payload, byte k at bits 8k+7..8k |
| rx_pending | output | NUM_MB | Per-mailbox pending flags |
| rx_irq | output | NUM_MB | Per-mailbox receive interrupt flags |
| msg_lost | output | NUM_MB | Per-mailbox message-lost flags |

## Verification
The assertions assume that frm_valid is a single-cycle strobe carrying a fully decoded frame. They also assume that the configuration port never targets an address outside the documented map, so every store is attributable to one frame. The bench drives each frame for exactly one cycle, on the falling edge. It places every register access between frames, except in the one scenario that deliberately overlaps a flag clear with a store. All addresses the bench uses come from the documented map.

// File: rtl/can_mbox_pkg.sv
package can_mbox_pkg;

  localparam int ID_W = 29;

  // Global register kinds (address bits above the half index)
  localparam int GK_EN   = 0;
  localparam int GK_DIR  = 1;
  localparam int GK_PEND = 2;
  localparam int GK_IRQ  = 3;
  localparam int GK_LOST = 4;

  // Mailbox register slots
  localparam logic [3:0] MR_ID_HI  = 4'd0;
  localparam logic [3:0] MR_ID_LO  = 4'd1;
  localparam logic [3:0] MR_MSK_HI = 4'd2;
  localparam logic [3:0] MR_MSK_LO = 4'd3;
  localparam logic [3:0] MR_LEN    = 4'd4;
  localparam logic [3:0] MR_DAT0   = 4'd5;
  localparam logic [3:0] MR_DAT3   = 4'd8;

  typedef struct packed {
    logic        ame;
    logic        rtr;
    logic        ide;
    logic [12:0] idb;
  } id_hi_t;

  // Acceptance test of one mailbox against one frame
  function automatic logic id_accept(input id_hi_t hi, input logic [15:0] lo,
                                     input logic [12:0] mhi, input logic [15:0] mlo,
                                     input logic ext, input logic rtr,
                                     input logic [ID_W-1:0] id);
    logic [ID_W-1:0] cand;
    logic [ID_W-1:0] want;
    logic [ID_W-1:0] care;
    cand = ext ? id : {id[10:0], 18'b0};
    want = {hi.idb, lo};
    care = hi.ame ? ~{mhi, mlo} : '1;
    if (!ext) care = care & {11'h7FF, 18'h0};
    return (hi.ide == ext) && (hi.ame || (hi.rtr == rtr)) &&
           (((cand ^ want) & care) == '0);
  endfunction

  // Upper identifier word written on a store
  function automatic id_hi_t rx_id_hi(input logic ame, input logic ext,
                                      input logic rtr, input logic [ID_W-1:0] id);
    id_hi_t r;
    r.ame = ame;
    r.rtr = rtr;
    r.ide = ext;
    r.idb = ext ? id[28:16] : {id[10:0], 2'b00};
    return r;
  endfunction

  // Data word w: lower-numbered byte in the high half
  function automatic logic [15:0] pack_word(input logic [63:0] d, input int w);
    return {d[16*w +: 8], d[16*w+8 +: 8]};
  endfunction

endpackage

// File: rtl/can_mbox_match.sv
module can_mbox_match
  import can_mbox_pkg::*;
#(
  parameter int NUM_MB = 32
) (
  input  id_hi_t [NUM_MB-1:0]        hi_q,
  input  logic   [NUM_MB-1:0][15:0]  lo_q,
  input  logic   [NUM_MB-1:0][12:0]  mhi_q,
  input  logic   [NUM_MB-1:0][15:0]  mlo_q,
  input  logic   [NUM_MB-1:0]        en_q,
  input  logic   [NUM_MB-1:0]        dir_q,
  input  logic                       frm_ext,
  input  logic                       frm_rtr,
  input  logic   [ID_W-1:0]          frm_id,
  output logic   [NUM_MB-1:0]        hit
);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
    assign hit[g] = en_q[g] & dir_q[g] &
                    id_accept(hi_q[g], lo_q[g], mhi_q[g], mlo_q[g],
                              frm_ext, frm_rtr, frm_id);
  end

endmodule

// File: rtl/can_mbox_prio.sv
module can_mbox_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/can_mbox_filter.sv
module can_mbox_filter
  import can_mbox_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int MB_W   = $clog2(NUM_MB),
  parameter int ADDR_W = MB_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [3:0]        frm_dlc,
  input  logic [63:0]       frm_data,
  output logic [NUM_MB-1:0] rx_pending,
  output logic [NUM_MB-1:0] rx_irq,
  output logic [NUM_MB-1:0] msg_lost
);

  localparam int NUM_HALF = NUM_MB / 16;
  localparam logic [MB_W-1:0] K_EN   = MB_W'(GK_EN);
  localparam logic [MB_W-1:0] K_DIR  = MB_W'(GK_DIR);
  localparam logic [MB_W-1:0] K_PEND = MB_W'(GK_PEND);
  localparam logic [MB_W-1:0] K_IRQ  = MB_W'(GK_IRQ);
  localparam logic [MB_W-1:0] K_LOST = MB_W'(GK_LOST);

  // Mailbox storage
  id_hi_t [NUM_MB-1:0]            hi_q;
  logic   [NUM_MB-1:0][15:0]      lo_q;
  logic   [NUM_MB-1:0][12:0]      mhi_q;
  logic   [NUM_MB-1:0][15:0]      mlo_q;
  logic   [NUM_MB-1:0][3:0]       len_q;
  logic   [NUM_MB-1:0][3:0][15:0] dat_q;

  // Global state
  logic [NUM_MB-1:0] en_q, dir_q, pend_q, irq_q, lost_q;
  logic [NUM_MB-1:0] en_n, dir_n, pend_n, irq_n, lost_n;

  // Address decode
  logic            is_mb;
  logic [MB_W-1:0] a_mb;
  logic [3:0]      a_sub;
  logic            mb_wr;
  logic            gl_wr;

  assign is_mb = cfg_addr[ADDR_W-1];
  assign a_mb  = cfg_addr[ADDR_W-2:4];
  assign a_sub = cfg_addr[3:0];
  assign mb_wr = cfg_we & is_mb;
  assign gl_wr = cfg_we & ~is_mb;

  // Named internal events
  logic [NUM_MB-1:0] hit_vec;
  logic              store_en;
  logic              hit_any;
  logic [MB_W-1:0]   store_idx;

  can_mbox_match #(.NUM_MB(NUM_MB)) i_match (
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .mhi_q   (mhi_q),
    .mlo_q   (mlo_q),
    .en_q    (en_q),
    .dir_q   (dir_q),
    .frm_ext (frm_ext),
    .frm_rtr (frm_rtr),
    .frm_id  (frm_id),
    .hit     (hit_vec)
  );

  can_mbox_prio #(.N(NUM_MB), .IDX_W(MB_W)) i_prio (
    .req (hit_vec),
    .any (hit_any),
    .idx (store_idx)
  );

  assign store_en = frm_valid & hit_any;

  // Mailbox register updates: a store beats a write to the same mailbox
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      mhi_q <= '0;
      mlo_q <= '0;
      len_q <= '0;
      dat_q <= '0;
    end else begin
      for (int m = 0; m < NUM_MB; m++) begin
        if (store_en && (store_idx == MB_W'(m))) begin
          hi_q[m] <= rx_id_hi(hi_q[m].ame, frm_ext, frm_rtr, frm_id);
          if (frm_ext) lo_q[m] <= frm_id[15:0];
          len_q[m] <= frm_dlc;
          for (int w = 0; w < 4; w++) dat_q[m][w] <= pack_word(frm_data, w);
        end else if (mb_wr && (a_mb == MB_W'(m))) begin
          case (a_sub)
            MR_ID_HI:  hi_q[m]  <= id_hi_t'(cfg_wdata);
            MR_ID_LO:  lo_q[m]  <= cfg_wdata;
            MR_MSK_HI: mhi_q[m] <= cfg_wdata[12:0];
            MR_MSK_LO: mlo_q[m] <= cfg_wdata;
            MR_LEN:    len_q[m] <= cfg_wdata[3:0];
            default: begin
              if (a_sub >= MR_DAT0 && a_sub <= MR_DAT3)
                dat_q[m][a_sub[1:0] - 2'd1] <= cfg_wdata;
            end
          endcase
        end
      end
    end
  end

  // Global next state: clears first, then store sets on top
  always_comb begin
    en_n   = en_q;
    dir_n  = dir_q;
    pend_n = pend_q;
    irq_n  = irq_q;
    lost_n = lost_q;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (gl_wr && (a_sub == 4'(h))) begin
        case (a_mb)
          K_EN:    en_n[16*h +: 16]   = cfg_wdata;
          K_DIR:   dir_n[16*h +: 16]  = cfg_wdata;
          K_PEND:  pend_n[16*h +: 16] = pend_q[16*h +: 16] & ~cfg_wdata;
          K_IRQ:   irq_n[16*h +: 16]  = irq_q[16*h +: 16] & ~cfg_wdata;
          K_LOST:  lost_n[16*h +: 16] = lost_q[16*h +: 16] & ~cfg_wdata;
          default: ;
        endcase
      end
    end
    if (store_en) begin
      pend_n[store_idx] = 1'b1;
      irq_n[store_idx]  = 1'b1;
      if (pend_q[store_idx]) lost_n[store_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      pend_q <= '0;
      irq_q  <= '0;
      lost_q <= '0;
    end else begin
      en_q   <= en_n;
      dir_q  <= dir_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
      lost_q <= lost_n;
    end
  end

  // Combinational read path
  always_comb begin
    cfg_rdata = '0;
    if (is_mb) begin
      case (a_sub)
        MR_ID_HI:  cfg_rdata = hi_q[a_mb];
        MR_ID_LO:  cfg_rdata = lo_q[a_mb];
        MR_MSK_HI: cfg_rdata = {3'b000, mhi_q[a_mb]};
        MR_MSK_LO: cfg_rdata = mlo_q[a_mb];
        MR_LEN:    cfg_rdata = {12'h000, len_q[a_mb]};
        default: begin
          if (a_sub >= MR_DAT0 && a_sub <= MR_DAT3)
            cfg_rdata = dat_q[a_mb][a_sub[1:0] - 2'd1];
        end
      endcase
    end else begin
      for (int h = 0; h < NUM_HALF; h++) begin
        if (a_sub == 4'(h)) begin
          case (a_mb)
            K_EN:    cfg_rdata = en_q[16*h +: 16];
            K_DIR:   cfg_rdata = dir_q[16*h +: 16];
            K_PEND:  cfg_rdata = pend_q[16*h +: 16];
            K_IRQ:   cfg_rdata = irq_q[16*h +: 16];
            K_LOST:  cfg_rdata = lost_q[16*h +: 16];
            default: ;
          endcase
        end
      end
    end
  end

  assign rx_pending = pend_q;
  assign rx_irq     = irq_q;
  assign msg_lost   = lost_q;

endmodule

// File: rtl/can_mbox_filter_chk.sv
module can_mbox_filter_chk #(
  parameter int NUM_MB = 32,
  parameter int MB_W   = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic [NUM_MB-1:0] hit_vec,
  input logic              store_en,
  input logic [MB_W-1:0]   store_idx,
  input logic [NUM_MB-1:0] en_q,
  input logic [NUM_MB-1:0] dir_q,
  input logic [NUM_MB-1:0] rx_pending,
  input logic [NUM_MB-1:0] rx_irq,
  input logic [NUM_MB-1:0] msg_lost
);

  logic [NUM_MB-1:0] below;
  assign below = (NUM_MB'(1) << store_idx) - NUM_MB'(1);

  // R7: a store only happens on a frame strobe
  p_store_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> frm_valid);

  // R5: the chosen mailbox is an enabled receiver that matched
  p_store_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> (en_q[store_idx] && dir_q[store_idx] && hit_vec[store_idx]));

  // R6: no lower-numbered mailbox matched
  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> ((hit_vec & below) == '0));

  // R7: store raises pending and interrupt of the winner
  p_store_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> (rx_pending[$past(store_idx)] && rx_irq[$past(store_idx)]));

  for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
    // R8: lost rises only on a store into a pending mailbox
    p_lost_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_lost[i]) |-> ($past(rx_pending[i]) && $past(store_en) &&
                              ($past(store_idx) == MB_W'(i))));
    // R9: interrupt flag is only raised by a store
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq[i]) |-> ($past(store_en) && ($past(store_idx) == MB_W'(i))));
  end

endmodule

bind can_mbox_filter can_mbox_filter_chk #(.NUM_MB(NUM_MB), .MB_W(MB_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_valid  (frm_valid),
  .hit_vec    (hit_vec),
  .store_en   (store_en),
  .store_idx  (store_idx),
  .en_q       (en_q),
  .dir_q      (dir_q),
  .rx_pending (rx_pending),
  .rx_irq     (rx_irq),
  .msg_lost   (msg_lost)
);

// File: tb/test_can_mbox_filter.sv
module test_can_mbox_filter;

  localparam int NUM_MB = 32;
  localparam int AW     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [AW-1:0]     cfg_addr = '0;
  logic [15:0]       cfg_wdata = '0;
  logic [15:0]       cfg_rdata;
  logic              frm_valid = 1'b0;
  logic              frm_ext = 1'b0;
  logic              frm_rtr = 1'b0;
  logic [28:0]       frm_id = '0;
  logic [3:0]        frm_dlc = '0;
  logic [63:0]       frm_data = '0;
  logic [NUM_MB-1:0] rx_pending, rx_irq, msg_lost;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  can_mbox_filter #(.NUM_MB(NUM_MB)) i_can_mbox_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid),
    .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_data(frm_data), .rx_pending(rx_pending), .rx_irq(rx_irq),
    .msg_lost(msg_lost)
  );

  function automatic logic [AW-1:0] mba(input int mb, input int r);
    return {1'b1, mb[4:0], r[3:0]};
  endfunction

  function automatic logic [AW-1:0] gla(input int kind, input int half);
    return {1'b0, kind[4:0], half[3:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                      input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_id = id;
    frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic set_mb(input int mb, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [15:0] mhi, input logic [15:0] mlo);
    wr(mba(mb, 0), hi);
    wr(mba(mb, 1), lo);
    wr(mba(mb, 2), mhi);
    wr(mba(mb, 3), mlo);
  endtask

  task automatic set_vec(input int kind, input logic [31:0] v);
    wr(gla(kind, 0), v[15:0]);
    wr(gla(kind, 1), v[31:16]);
  endtask

  task automatic fresh();
    set_vec(0, 32'h0);
    set_vec(1, 32'h0);
    set_vec(2, 32'hFFFF_FFFF);
    set_vec(3, 32'hFFFF_FFFF);
    set_vec(4, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1", "pending after reset", rx_pending, 32'h0);
    check("R1", "irq after reset", rx_irq, 32'h0);
    check("R1", "lost after reset", msg_lost, 32'h0);
    rd(gla(0, 0), d); check("R1", "enable half0", {16'h0, d}, 32'h0);
    rd(mba(3, 0), d); check("R1", "mb3 id upper", {16'h0, d}, 32'h0);
    send(1'b0, 1'b0, 29'h0, 4'd0, 64'h0);
    check("R5", "no store with bank disabled", rx_pending, 32'h0);
  endtask

  task automatic t_std();
    fresh();
    set_mb(2, 16'(11'h123 << 2), 16'h0, 16'h0, 16'h0);
    set_vec(0, 32'h4); set_vec(1, 32'h4);
    send(1'b0, 1'b0, 29'h123, 4'd1, 64'h0);
    check("R2", "exact std id hit", rx_pending, 32'h4);
    set_vec(2, 32'hFFFF_FFFF);
    send(1'b0, 1'b0, 29'h124, 4'd1, 64'h0);
    check("R2", "different std id miss", rx_pending, 32'h0);
    send(1'b0, 1'b1, 29'h123, 4'd1, 64'h0);
    check("R2", "remote flag mismatch miss", rx_pending, 32'h0);
    send(1'b1, 1'b0, 29'h123 << 18, 4'd1, 64'h0);
    check("R4", "extended frame vs std mailbox miss", rx_pending, 32'h0);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    fresh();
    set_mb(5, 16'h2000 | 16'h1ABC, 16'hDE12, 16'h0, 16'h0);
    set_vec(0, 32'h20); set_vec(1, 32'h20);
    send(1'b1, 1'b0, 29'h1ABC_DE13, 4'd0, 64'h0);
    check("R3", "ext id off by one miss", rx_pending, 32'h0);
    send(1'b1, 1'b0, 29'h1ABC_DE12, 4'd0, 64'h0);
    check("R3", "exact ext id hit", rx_pending, 32'h20);
    rd(mba(5, 1), d); check("R3", "lower id word kept", {16'h0, d}, 32'hDE12);
    rd(mba(5, 0), d); check("R3", "upper id word", {16'h0, d}, 32'h3ABC);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    fresh();
    set_mb(7, 16'h8000 | 16'(11'h120 << 2), 16'h0, 16'h003C, 16'hFFFF);
    set_vec(0, 32'h80); set_vec(1, 32'h80);
    send(1'b0, 1'b0, 29'h13A, 4'd0, 64'h0);
    check("R4", "cared bit differs miss", rx_pending, 32'h0);
    send(1'b1, 1'b0, 29'h120 << 18, 4'd0, 64'h0);
    check("R4", "format must match under mask", rx_pending, 32'h0);
    send(1'b0, 1'b1, 29'h12A, 4'd0, 64'h0);
    check("R4", "masked bits and remote ignored", rx_pending, 32'h80);
    rd(mba(7, 0), d); check("R7", "stored id keeps mask enable", {16'h0, d}, 32'hC4A8);
  endtask

  task automatic t_gating();
    fresh();
    set_mb(9, 16'h8000, 16'h0, 16'h1FFF, 16'hFFFF);
    set_vec(0, 32'h200); set_vec(1, 32'h0);
    send(1'b0, 1'b0, 29'h55, 4'd0, 64'h0);
    check("R5", "transmit-direction mailbox ignores", rx_pending, 32'h0);
    set_vec(0, 32'h0); set_vec(1, 32'h200);
    send(1'b0, 1'b0, 29'h55, 4'd0, 64'h0);
    check("R5", "disabled mailbox ignores", rx_pending, 32'h0);
    set_vec(0, 32'h200);
    send(1'b0, 1'b0, 29'h55, 4'd0, 64'h0);
    check("R5", "enabled receiver accepts", rx_pending, 32'h200);
  endtask

  task automatic t_priority();
    fresh();
    set_mb(20, 16'h8000, 16'h0, 16'h1FFF, 16'hFFFF);
    set_mb(3, 16'h8000, 16'h0, 16'h1FFF, 16'hFFFF);
    set_vec(0, 32'h0010_0200); set_vec(1, 32'h0010_0200);
    send(1'b0, 1'b0, 29'h7FF, 4'd0, 64'h0);
    check("R6", "mb9 beats mb20", rx_pending, 32'h200);
    set_vec(0, 32'h0010_0208); set_vec(1, 32'h0010_0208);
    send(1'b0, 1'b0, 29'h001, 4'd0, 64'h0);
    check("R6", "mb3 beats mb9 and mb20", rx_pending, 32'h208);
  endtask

  task automatic t_payload();
    logic [15:0] d;
    fresh();
    set_mb(1, 16'hA000, 16'h0, 16'h1FFF, 16'hFFFF);
    set_vec(0, 32'h2); set_vec(1, 32'h2);
    @(negedge clk);
    check("R7", "no flag before store", rx_irq, 32'h0);
    send(1'b1, 1'b0, 29'h0ABC_1234, 4'd5, 64'h8877_6655_4433_2211);
    check("R7", "irq set next cycle", rx_irq, 32'h2);
    rd(mba(1, 4), d); check("R7", "length code", {16'h0, d}, 32'h5);
    rd(mba(1, 5), d); check("R7", "data word0 packing", {16'h0, d}, 32'h1122);
    rd(mba(1, 8), d); check("R7", "data word3 packing", {16'h0, d}, 32'h7788);
    rd(mba(1, 1), d); check("R10", "lower id via map", {16'h0, d}, 32'h1234);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    check("R8", "lost clear after first store", msg_lost, 32'h0);
    send(1'b1, 1'b0, 29'h0000_0042, 4'd2, 64'h0000_0000_0000_BBAA);
    check("R8", "lost set on overwrite", msg_lost, 32'h2);
    rd(mba(1, 5), d); check("R8", "new data replaces", {16'h0, d}, 32'hAABB);
    rd(gla(4, 0), d); check("R10", "lost readable in global space", {16'h0, d}, 32'h2);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(gla(2, 0), 16'h0000);
    check("R9", "writing 0 keeps pending", rx_pending, 32'h2);
    wr(gla(2, 0), 16'h0002);
    check("R9", "w1c pending", rx_pending, 32'h0);
    check("R9", "irq independent of pending clear", rx_irq, 32'h2);
    wr(gla(3, 0), 16'h0002);
    check("R9", "w1c irq", rx_irq, 32'h0);
    wr(gla(4, 0), 16'h0002);
    check("R9", "w1c lost", msg_lost, 32'h0);
    // upper half
    set_mb(24, 16'h8000, 16'h0, 16'h1FFF, 16'hFFFF);
    set_vec(0, 32'h0100_0000); set_vec(1, 32'h0100_0000);
    send(1'b0, 1'b0, 29'h10, 4'd0, 64'h0);
    check("R9", "mb24 pending", rx_pending, 32'h0100_0000);
    rd(gla(2, 1), d); check("R10", "pending half1 read", {16'h0, d}, 32'h0100);
    // clear and store in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = gla(2, 1); cfg_wdata = 16'h0100;
    frm_valid = 1'b1; frm_ext = 1'b0; frm_rtr = 1'b0; frm_id = 29'h11;
    @(negedge clk);
    cfg_we = 1'b0; frm_valid = 1'b0;
    check("R9", "store beats same-cycle clear", rx_pending, 32'h0100_0000);
    check("R8", "overwrite during clear is lost", msg_lost, 32'h0100_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std();
    t_ext();
    t_mask();
    t_gating();
    t_priority();
    t_payload();
    t_overrun();
    t_w1c();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule